// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces, one per clock, the column addresses that a single SDRAM read or write burst visits. A controller pulses `start_i` with the first column of the access, along with a burst length code and an ordering select. From the following cycle the block presents one column per cycle on `col_o` with `valid_o` high. It raises `last_o` on the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 and 8 beats stay inside the naturally aligned block that holds the start column. They are visited either by counting up with wrap-around, or by XOR-ing the start column's low bits with the beat number. A full-page burst walks the whole column space, wrapping from the highest column back to zero, until a terminate pulse stops it. A new `start_i` on any cycle drops the running burst and begins the new one at once. Command decoding and the data path belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held (synchronous, active low) and in the cycle after, `valid_o` and `last_o` are 0 and `col_o` is 0. `col_o` also reads 0 whenever `valid_o` is 0.
- R2: A burst loads from `start_i` sampled high at a rising edge. In the cycle after that edge, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`.
- R3: `len_code_i` selects the beat count: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats and 7 gives full page. Codes 4, 5 and 6 behave as 1 beat. A fixed burst keeps `valid_o` high for exactly that many consecutive cycles.
- R4: When `order_ilv_i` = 0 (sequential), beat n takes the low log2(length) bits of the start column plus n, modulo the length. The remaining upper bits equal those of the start column.
- R5: When `order_ilv_i` = 1 (interleaved), beat n equals the start column with its low log2(length) bits XOR-ed with n.
- R6: In full-page mode, beat n is (start column + n) modulo 2^COL_W. The burst keeps `valid_o` high until it is terminated or restarted.
- R7: `last_o` is 1 only on the final beat of a fixed-length burst. It is 0 on every other beat and throughout a full-page burst. `valid_o` drops in the cycle after the last beat unless a new start arrived.
- R8: `term_i` sampled high at an edge while `start_i` is low ends the burst, so `valid_o` is 0 from the next cycle. While idle it has no effect.
- R9: `start_i` sampled high during a running burst abandons it, and the next cycle shows the new start column. If `start_i` and `term_i` are both high at the same edge, the start wins.
- R10: Full-page length requested together with `order_ilv_i` = 1 runs as a sequential full-page burst.
- R11: Length and ordering are captured at the start edge. Changes on `len_code_i`, `order_ilv_i` or `start_col_i` during the burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new burst this edge |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code (0,1,2,3 fixed; 7 full page) |
| order_ilv_i | input | 1 | 0 sequential, 1 interleaved ordering |
| term_i | input | 1 | Stop the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench builds the block with its default COL_W of 9, so the column space has 512 entries. At that width a full-page burst that starts a few columns below 511 crosses the wrap to zero within a handful of beats. Eight-beat bursts that start near the top of the space show that both orderings stay inside their aligned block and never carry into the upper bits. The default width also keeps every length code, including the reserved ones, reachable from a short table of vectors.

// File: rtl/burst_col_pkg.sv
// Shared constants and types for the burst column generator.
// Assumes a three-bit length code whose fixed lengths are powers of two up to 8.
package burst_col_pkg;

    localparam int LEN_CODE_W = 3;

    localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'd0;
    localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'd1;
    localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'd2;
    localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'd3;
    localparam logic [LEN_CODE_W-1:0] LEN_FULL  = 3'd7;

    // Smallest column width that can hold an eight-beat block.
    localparam int MIN_COL_W = 3;

    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_ILV = 1'b1
    } order_e;

endpackage

// File: rtl/burst_len_decode.sv
// Turns the length code and ordering request into a low-bit wrap mask,
// a full-page flag and the ordering that actually applies.
// Assumes COL_W >= MIN_COL_W; reserved codes decode as a single beat.
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  order_e                order_req,
    output logic [COL_W-1:0]      wrap_mask,
    output logic                  full_page,
    output order_e                order_eff
);

    // Map each length code onto the set of column bits that move.
    always_comb begin
        full_page = 1'b0;
        wrap_mask = '0;
        case (len_code)
            LEN_TWO:   wrap_mask = COL_W'(1);
            LEN_FOUR:  wrap_mask = COL_W'(3);
            LEN_EIGHT: wrap_mask = COL_W'(7);
            LEN_FULL: begin
                wrap_mask = '1;
                full_page = 1'b1;
            end
            default:   wrap_mask = '0;
        endcase
    end

    // Full page is sequential only, so an interleaved request is overridden.
    always_comb begin
        order_eff = full_page ? ORDER_SEQ : order_req;
    end

endmodule

// File: rtl/burst_beat_counter.sv
// Holds the burst configuration captured at start and counts beats.
// Start takes priority over terminate; a fixed burst ends after the beat
// whose index equals the wrap mask, a full-page burst only on terminate.
module burst_beat_counter
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] mask_in,
    input  logic             full_in,
    input  order_e           order_in,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] mask_q,
    output logic             full_q,
    output order_e           order_q,
    output logic             last
);

    // Final beat of a fixed-length burst.
    always_comb begin
        last = active && !full_q && (beat == mask_q);
    end

    // Load on start, stop on terminate or after the last beat, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            beat    <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            order_q <= ORDER_SEQ;
        end else if (start) begin
            active  <= 1'b1;
            beat    <= '0;
            mask_q  <= mask_in;
            full_q  <= full_in;
            order_q <= order_in;
        end else if (term) begin
            active  <= 1'b0;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    // R3: a fixed burst's beat index never leaves the masked low bits.
    a_r3_beat_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !full_q) |-> ((beat & ~mask_q) == '0));

    // R8: terminate without start leaves the counter idle.
    a_r8_term_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !active);

    // R9: a start always rearms the counter at beat zero.
    a_r9_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && beat == '0));

endmodule

// File: rtl/burst_col_mapper.sv
// Combines the captured start column with the beat index into a column.
// Bits outside the wrap mask pass through; masked bits take either the
// low bits of base+beat (sequential) or base XOR beat (interleaved).
module burst_col_mapper
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  order_e           order,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;

    // Wrapping sum used by sequential ordering.
    always_comb begin
        sum = base + beat;
    end

    // One selector per column bit.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask[i]) begin
                col[i] = base[i];
            end else if (order == ORDER_ILV) begin
                col[i] = base[i] ^ beat[i];
            end else begin
                col[i] = sum[i];
            end
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
// Top level: column address sequencer for one SDRAM burst.
// Assumes start and terminate are single-cycle requests from a controller;
// col_o reads zero whenever no beat is presented.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  order_ilv_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    order_e           dec_order;
    logic             act;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    order_e           order_q;
    logic             last;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mapped;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code  (len_code_i),
        .order_req (order_e'(order_ilv_i)),
        .wrap_mask (dec_mask),
        .full_page (dec_full),
        .order_eff (dec_order)
    );

    burst_beat_counter #(.COL_W(COL_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .term     (term_i),
        .mask_in  (dec_mask),
        .full_in  (dec_full),
        .order_in (dec_order),
        .active   (act),
        .beat     (beat),
        .mask_q   (mask_q),
        .full_q   (full_q),
        .order_q  (order_q),
        .last     (last)
    );

    // Capture the start column of each new burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (start_i) begin
            base_q <= start_col_i;
        end
    end

    burst_col_mapper #(.COL_W(COL_W)) u_map (
        .base  (base_q),
        .beat  (beat),
        .mask  (mask_q),
        .order (order_q),
        .col   (mapped)
    );

    // Drive the outputs, forcing the column to zero while idle.
    always_comb begin
        valid_o = act;
        last_o  = last;
        col_o   = act ? mapped : '0;
    end

    // R2: the first beat shows the column sampled with the start.
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R7: the last flag is only ever raised on a presented beat.
    a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R7: after the last beat, the burst closes unless restarted.
    a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R6: a full-page burst keeps running without terminate or restart.
    a_r6_full_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && full_q && !term_i && !start_i) |=> valid_o);

    // R4: sequential beats advance the masked bits by one with wrap.
    a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !term_i && order_q == ORDER_SEQ)
        |=> ((col_o & mask_q) == (($past(col_o) + 1'b1) & mask_q)));

    // R5: interleaved beats never disturb bits outside the mask.
    a_r5_ilv_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !term_i && order_q == ORDER_ILV)
        |=> (((col_o ^ $past(col_o)) & ~mask_q) == '0));

    // R1: idle output column reads zero.
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0 && !last_o));

endmodule

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       order_ilv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(9)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .order_ilv_i (order_ilv_i),
        .term_i      (term_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    // Vector: {start column, length code, interleave}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {9'd5,   3'd0, 1'b0},
        {9'd13,  3'd1, 1'b0},
        {9'd13,  3'd1, 1'b1},
        {9'd5,   3'd2, 1'b0},
        {9'd5,   3'd2, 1'b1},
        {9'd507, 3'd3, 1'b0},
        {9'd507, 3'd3, 1'b1},
        {9'd0,   3'd3, 1'b0},
        {9'd42,  3'd3, 1'b1},
        {9'd100, 3'd4, 1'b0},
        {9'd100, 3'd6, 1'b1},
        {9'd77,  3'd5, 1'b0}
    };

    function automatic int blen(int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(int base, int n, int code, bit ilv);
        int len;
        if (code == 7) return (base + n) % 512;
        len = blen(code);
        if (ilv) return base ^ n;
        return (base / len) * len + ((base % len + n) % len);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Run one fixed burst, scrambling the config inputs after the start (R11).
    task automatic run_burst(int c, int code, bit ilv);
        int n;
        n = blen(code);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'(c); len_code_i = 3'(code); order_ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0; start_col_i = 9'(c + 3); len_code_i = 3'd7; order_ilv_i = ~ilv;
        for (int i = 0; i < n; i++) begin
            check("R2/R3 valid", int'(valid_o), 1);
            check(ilv ? "R5/R11 col" : "R4/R11 col", int'(col_o), exp_col(c, i, code, ilv));
            check("R7 last", int'(last_o), (i == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R3 end of burst", int'(valid_o), 0);
        check("R1 idle col", int'(col_o), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(valid_o), 0);
        check("R1 last in reset", int'(last_o), 0);
        check("R1 col in reset", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(valid_o), 0);

        // Table of bursts (R3, R4, R5, R7, R11)
        for (int v = 0; v < NV; v++) begin
            run_burst(int'(VEC[v][12:4]), int'(VEC[v][3:1]), VEC[v][0]);
        end

        // R8: terminate while idle has no effect
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R8 idle term valid", int'(valid_o), 0);
        check("R8 idle term col", int'(col_o), 0);

        // R6: full page wraps past 511 and runs on; R7 never last
        start_i = 1'b1; start_col_i = 9'd505; len_code_i = 3'd7; order_ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            check("R6 full valid", int'(valid_o), 1);
            check("R6 full col", int'(col_o), (505 + i) % 512);
            check("R7 full no last", int'(last_o), 0);
            if (i == 19) term_i = 1'b1;
            @(negedge clk);
        end
        term_i = 1'b0;
        check("R8 full terminated", int'(valid_o), 0);

        // R10: interleave with full page runs sequentially
        start_i = 1'b1; start_col_i = 9'd510; len_code_i = 3'd7; order_ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            check("R10 ilv full col", int'(col_o), (510 + i) % 512);
            check("R10 ilv full last", int'(last_o), 0);
            @(negedge clk);
        end
        // R9: start and terminate together, start wins
        start_i = 1'b1; term_i = 1'b1; start_col_i = 9'd200; len_code_i = 3'd2; order_ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R9 start over term valid", int'(valid_o), 1);
            check("R9 start over term col", int'(col_o), 200 + i);
            @(negedge clk);
        end
        check("R9 burst after restart ends", int'(valid_o), 0);

        // R9: restart in the middle of an eight-beat burst
        start_i = 1'b1; start_col_i = 9'd8; len_code_i = 3'd3; order_ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R4 pre-restart beat0", int'(col_o), 8);
        @(negedge clk);
        check("R4 pre-restart beat1", int'(col_o), 9);
        start_i = 1'b1; start_col_i = 9'd41; len_code_i = 3'd1; order_ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R9 restart col0", int'(col_o), 41);
        check("R9 restart last0", int'(last_o), 0);
        @(negedge clk);
        check("R9 restart col1", int'(col_o), 40);
        check("R9 restart last1", int'(last_o), 1);
        @(negedge clk);
        check("R9 restart ends", int'(valid_o), 0);

        // R8: terminate mid fixed burst
        start_i = 1'b1; start_col_i = 9'd16; len_code_i = 3'd3; order_ilv_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 mid beat0", int'(col_o), 16);
        @(negedge clk);
        check("R8 mid beat1", int'(col_o), 17);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R8 mid term valid", int'(valid_o), 0);
        check("R8 mid term last", int'(last_o), 0);
        @(negedge clk);
        check("R8 stays idle", int'(valid_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule